// File: doc/BRIEF.md
# Paged Serial Register Command Front End

This block sits behind a serial slave port and turns a stream of 16-bit words into register-file accesses. Words arrive in parallel with a valid strobe and a length field that tells how many bits the link shifted. A transaction is a command word followed by a data word. The command word carries a direction bit, a page number and a register offset. The block then either writes the data word into the selected page or returns the addressed register.

Reads are sequential. Each read advances the latched offset by one, and the block goes back to waiting for a command. A host can therefore clock out all-zero words and receive consecutive registers. Pages 0 to 2 are the only legal ones.

One location in the control page is a reset key. Writing the key value there pulses a soft-reset output for the neighbouring blocks and clears the command state. The register-file strobes are combinational in the cycle the word is presented. Read data, error pulses and the soft-reset pulse are registered and appear one cycle later.

Top module: `pcmd_frontend`

## Requirements
- R1: A valid word whose length field is not 16 produces a one-cycle `err_len_o` pulse on the next cycle. The word causes no strobe and leaves the command state unchanged.
- R2: In the command phase a nonzero word is latched as a command: bit 15 set means read, bits 14:11 give the page and bits 10:5 give the offset, while bits 4:0 are ignored. Latching causes no strobe and no read data.
- R3: In the write phase any word, zero included, asserts `rf_wr_o` in the same cycle with the latched page and offset and the word on `rf_wdata_o`. The offset is left unchanged and the block returns to the command phase.
- R4: A read occurs on a zero word in the command phase, or on any word while a read command is pending. A read asserts `rf_rd_o` in the same cycle and presents `rd_valid_o`/`rd_data_o` on the next cycle. It increments the offset modulo 64 and returns the block to the command phase.
- R5: A nonzero word arriving while a read command is pending still performs the read. It pulses `err_overrun_o` together with `rd_valid_o`, and the word is neither written nor latched as a command.
- R6: A zero word in the command phase when the last latched command was not a read (or none since reset) pulses `err_underrun_o`. The read is still performed.
- R7: Pages 0, 1 and 2 are valid. An access to page 3 or above pulses `err_page_o`, raises no strobe, and a read of it returns 0xFFFF.
- R8: A read of a register the register file reports as absent (`rf_hit_i` low) returns 0xFFFF.
- R9: Writing 0xBB00 to page 1, offset 4 pulses `soft_rst_o` on the next cycle. The write raises no `rf_wr_o`, and it clears the state to command phase, page 0, offset 0, with no read pending.
- R10: Any other value written to page 1, offset 4 is ignored, with no strobe and no pulse. A read of that location returns 0xFFFF without `rf_rd_o`.
- R11: After synchronous reset the block is in the command phase at page 0, offset 0, with no read pending, and all registered outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_valid_i | input | 1 | Incoming word strobe |
| word_len_i | input | 5 | Number of bits the link shifted for this word |
| word_i | input | 16 | Incoming word |
| rf_rd_o | output | 1 | Register-file read strobe (same cycle as the word) |
| rf_wr_o | output | 1 | Register-file write strobe (same cycle as the word) |
| rf_page_o | output | 4 | Latched page |
| rf_ofs_o | output | 6 | Latched register offset |
| rf_wdata_o | output | 16 | Write data |
| rf_rdata_i | input | 16 | Register-file read data |
| rf_hit_i | input | 1 | Register exists at the addressed page/offset |
| rd_valid_o | output | 1 | Read data valid pulse |
| rd_data_o | output | 16 | Read data returned to the link |
| err_overrun_o | output | 1 | Overrun pulse |
| err_underrun_o | output | 1 | Underrun pulse |
| err_page_o | output | 1 | Invalid page pulse |
| err_len_o | output | 1 | Bad word length pulse |
| soft_rst_o | output | 1 | Soft-reset pulse to neighbouring blocks |

## Verification
The hardest situations to reach are the ones where a single word plays two roles. One is a nonzero word arriving while a read is pending: it must read, flag overrun, and be kept from becoming a command. The other is a sequential read run that crosses the key location, the boundary of present registers and the offset wrap from 63 to 0. The stimulus latches one read command per page at offset 0 and then streams 65 zero words, so every offset, the wrap and the key location are read back in one run. The overrun word is chosen to encode a different page and offset, so that a wrongly latched command would show up in the address of the following read.

// File: rtl/pcmd_pkg.sv
package pcmd_pkg;
    localparam int WORD_W = 16;
    localparam int LEN_W  = 5;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_BADLEN,
        ACT_CMD,
        ACT_WRITE,
        ACT_READ,
        ACT_READ_OVR
    } act_e;
endpackage

// File: rtl/pcmd_classify.sv
module pcmd_classify
    import pcmd_pkg::*;
(
    input  logic              valid_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              phase_i,
    input  logic              cmd_rd_i,
    output act_e              act_o
);
    localparam logic [LEN_W-1:0] GOOD_LEN = LEN_W'(WORD_W);

    always_comb begin
        act_o = ACT_IDLE;
        if (valid_i) begin
            if (len_i != GOOD_LEN) begin
                act_o = ACT_BADLEN;
            end else if (phase_i && cmd_rd_i) begin
                act_o = (word_i == '0) ? ACT_READ : ACT_READ_OVR;
            end else if (phase_i) begin
                act_o = ACT_WRITE;
            end else if (word_i == '0) begin
                act_o = ACT_READ;
            end else begin
                act_o = ACT_CMD;
            end
        end
    end
endmodule

// File: rtl/pcmd_route.sv
module pcmd_route
    import pcmd_pkg::*;
#(
    parameter int                PAGE_W    = 4,
    parameter int                OFS_W     = 6,
    parameter int                NUM_PAGES = 3,
    parameter int                CTRL_PAGE = 1,
    parameter int                KEY_OFS   = 4,
    parameter logic [WORD_W-1:0] KEY_VAL   = 16'hBB00
) (
    input  act_e              act_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [WORD_W-1:0] rf_rdata_i,
    input  logic              rf_hit_i,
    output logic              rf_rd_o,
    output logic              rf_wr_o,
    output logic              page_bad_o,
    output logic              key_fire_o,
    output logic [WORD_W-1:0] rd_value_o
);
    localparam logic [WORD_W-1:0] FILL = '1;

    logic is_read, is_write, page_ok, key_loc;

    always_comb begin
        is_read    = (act_i == ACT_READ) || (act_i == ACT_READ_OVR);
        is_write   = (act_i == ACT_WRITE);
        page_ok    = page_i < PAGE_W'(NUM_PAGES);
        key_loc    = (page_i == PAGE_W'(CTRL_PAGE)) && (ofs_i == OFS_W'(KEY_OFS));
        rf_rd_o    = is_read && page_ok && !key_loc;
        rf_wr_o    = is_write && page_ok && !key_loc;
        page_bad_o = (is_read || is_write) && !page_ok;
        key_fire_o = is_write && key_loc && (word_i == KEY_VAL);
        rd_value_o = (rf_rd_o && rf_hit_i) ? rf_rdata_i : FILL;
    end
endmodule

// File: rtl/pcmd_frontend.sv
module pcmd_frontend
    import pcmd_pkg::*;
#(
    parameter int                PAGE_W    = 4,
    parameter int                OFS_W     = 6,
    parameter int                NUM_PAGES = 3,
    parameter int                CTRL_PAGE = 1,
    parameter int                KEY_OFS   = 4,
    parameter logic [WORD_W-1:0] KEY_VAL   = 16'hBB00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid_i,
    input  logic [LEN_W-1:0]  word_len_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              rf_rd_o,
    output logic              rf_wr_o,
    output logic [PAGE_W-1:0] rf_page_o,
    output logic [OFS_W-1:0]  rf_ofs_o,
    output logic [WORD_W-1:0] rf_wdata_o,
    input  logic [WORD_W-1:0] rf_rdata_i,
    input  logic              rf_hit_i,
    output logic              rd_valid_o,
    output logic [WORD_W-1:0] rd_data_o,
    output logic              err_overrun_o,
    output logic              err_underrun_o,
    output logic              err_page_o,
    output logic              err_len_o,
    output logic              soft_rst_o
);
    localparam int RD_BIT   = WORD_W - 1;
    localparam int PAGE_LSB = RD_BIT - PAGE_W;
    localparam int OFS_LSB  = PAGE_LSB - OFS_W;

    typedef struct packed {
        logic              phase;
        logic              cmd_rd;
        logic [PAGE_W-1:0] page;
        logic [OFS_W-1:0]  ofs;
        logic              rd_valid;
        logic [WORD_W-1:0] rd_data;
        logic              e_ovr;
        logic              e_und;
        logic              e_page;
        logic              e_len;
        logic              srst;
    } st_t;

    localparam st_t ST_RESET = '0;

    st_t  st_d, st_q;
    act_e act;
    logic page_bad, key_fire;
    logic [WORD_W-1:0] rd_value;

    pcmd_classify u_classify (
        .valid_i  (word_valid_i),
        .len_i    (word_len_i),
        .word_i   (word_i),
        .phase_i  (st_q.phase),
        .cmd_rd_i (st_q.cmd_rd),
        .act_o    (act)
    );

    pcmd_route #(
        .PAGE_W    (PAGE_W),
        .OFS_W     (OFS_W),
        .NUM_PAGES (NUM_PAGES),
        .CTRL_PAGE (CTRL_PAGE),
        .KEY_OFS   (KEY_OFS),
        .KEY_VAL   (KEY_VAL)
    ) u_route (
        .act_i      (act),
        .page_i     (st_q.page),
        .ofs_i      (st_q.ofs),
        .word_i     (word_i),
        .rf_rdata_i (rf_rdata_i),
        .rf_hit_i   (rf_hit_i),
        .rf_rd_o    (rf_rd_o),
        .rf_wr_o    (rf_wr_o),
        .page_bad_o (page_bad),
        .key_fire_o (key_fire),
        .rd_value_o (rd_value)
    );

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = 1'b0;
        st_d.e_ovr    = 1'b0;
        st_d.e_und    = 1'b0;
        st_d.e_page   = 1'b0;
        st_d.e_len    = 1'b0;
        st_d.srst     = 1'b0;
        case (act)
            ACT_BADLEN: begin
                st_d.e_len = 1'b1;
            end
            ACT_CMD: begin
                st_d.phase  = 1'b1;
                st_d.cmd_rd = word_i[RD_BIT];
                st_d.page   = word_i[PAGE_LSB +: PAGE_W];
                st_d.ofs    = word_i[OFS_LSB +: OFS_W];
            end
            ACT_WRITE: begin
                st_d.phase  = 1'b0;
                st_d.e_page = page_bad;
                if (key_fire) begin
                    st_d.cmd_rd = 1'b0;
                    st_d.page   = '0;
                    st_d.ofs    = '0;
                    st_d.srst   = 1'b1;
                end
            end
            ACT_READ, ACT_READ_OVR: begin
                st_d.phase    = 1'b0;
                st_d.rd_valid = 1'b1;
                st_d.rd_data  = rd_value;
                st_d.ofs      = st_q.ofs + OFS_W'(1);
                st_d.e_page   = page_bad;
                st_d.e_ovr    = (act == ACT_READ_OVR);
                st_d.e_und    = (act == ACT_READ) && !st_q.phase && !st_q.cmd_rd;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign rf_page_o      = st_q.page;
    assign rf_ofs_o       = st_q.ofs;
    assign rf_wdata_o     = word_i;
    assign rd_valid_o     = st_q.rd_valid;
    assign rd_data_o      = st_q.rd_data;
    assign err_overrun_o  = st_q.e_ovr;
    assign err_underrun_o = st_q.e_und;
    assign err_page_o     = st_q.e_page;
    assign err_len_o      = st_q.e_len;
    assign soft_rst_o     = st_q.srst;
endmodule

// File: rtl/pcmd_frontend_chk.sv
module pcmd_frontend_chk
    import pcmd_pkg::*;
#(
    parameter int                PAGE_W    = 4,
    parameter int                OFS_W     = 6,
    parameter int                NUM_PAGES = 3,
    parameter int                CTRL_PAGE = 1,
    parameter int                KEY_OFS   = 4,
    parameter logic [WORD_W-1:0] KEY_VAL   = 16'hBB00
) (
    input logic              clk,
    input logic              rst_n,
    input logic              word_valid_i,
    input logic [LEN_W-1:0]  word_len_i,
    input logic [WORD_W-1:0] word_i,
    input logic              rf_rd_o,
    input logic              rf_wr_o,
    input logic [PAGE_W-1:0] rf_page_o,
    input logic [OFS_W-1:0]  rf_ofs_o,
    input logic              rd_valid_o,
    input logic              err_overrun_o,
    input logic              err_underrun_o,
    input logic              err_page_o,
    input logic              err_len_o,
    input logic              soft_rst_o
);
    localparam logic [LEN_W-1:0] GOOD_LEN = LEN_W'(WORD_W);

    assert_len_nostrobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid_i && word_len_i != GOOD_LEN) |-> (!rf_rd_o && !rf_wr_o));

    assert_len_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid_i && word_len_i != GOOD_LEN) |=> (err_len_o && !rd_valid_o));

    assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid_i |=> (!rd_valid_o && !err_len_o && !err_page_o && !soft_rst_o));

    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_rd_o && rf_wr_o));

    assert_read_return_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd_o |=> rd_valid_o);

    assert_read_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> (rf_ofs_o == OFS_W'($past(rf_ofs_o) + OFS_W'(1))));

    assert_overrun_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_overrun_o |-> (rd_valid_o && !err_underrun_o));

    assert_underrun_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_underrun_o |-> rd_valid_o);

    assert_page_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_rd_o || rf_wr_o) |-> (rf_page_o < PAGE_W'(NUM_PAGES)));

    assert_key_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |-> $past(word_valid_i && word_i == KEY_VAL
                             && rf_page_o == PAGE_W'(CTRL_PAGE) && rf_ofs_o == OFS_W'(KEY_OFS)));

    assert_key_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |-> (rf_page_o == '0 && rf_ofs_o == '0));

    assert_key_nowrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_o |-> !(rf_page_o == PAGE_W'(CTRL_PAGE) && rf_ofs_o == OFS_W'(KEY_OFS)));
endmodule

bind pcmd_frontend pcmd_frontend_chk #(
    .PAGE_W    (PAGE_W),
    .OFS_W     (OFS_W),
    .NUM_PAGES (NUM_PAGES),
    .CTRL_PAGE (CTRL_PAGE),
    .KEY_OFS   (KEY_OFS),
    .KEY_VAL   (KEY_VAL)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .word_valid_i   (word_valid_i),
    .word_len_i     (word_len_i),
    .word_i         (word_i),
    .rf_rd_o        (rf_rd_o),
    .rf_wr_o        (rf_wr_o),
    .rf_page_o      (rf_page_o),
    .rf_ofs_o       (rf_ofs_o),
    .rd_valid_o     (rd_valid_o),
    .err_overrun_o  (err_overrun_o),
    .err_underrun_o (err_underrun_o),
    .err_page_o     (err_page_o),
    .err_len_o      (err_len_o),
    .soft_rst_o     (soft_rst_o)
);

// File: tb/pcmd_frontend_tb_top.sv
module pcmd_frontend_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid = 1'b0;
    logic [4:0]  word_len = 5'd16;
    logic [15:0] word = '0;
    logic        rf_rd, rf_wr, rf_hit;
    logic [3:0]  rf_page;
    logic [5:0]  rf_ofs;
    logic [15:0] rf_wdata, rf_rdata, rd_data;
    logic        rd_valid, e_ovr, e_und, e_pg, e_len, srst;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic        c_rd, c_wr;
    logic [3:0]  c_page;
    logic [5:0]  c_ofs;
    logic [15:0] c_wdata;
    logic        r_valid, r_ovr, r_und, r_pg, r_len, r_srst;
    logic [15:0] r_data;

    always #10 clk = ~clk;

    assign rf_rdata = {2'b10, rf_page, rf_ofs, 4'h3};
    assign rf_hit   = (rf_ofs < 6'd40);

    pcmd_frontend dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .word_valid_i   (word_valid),
        .word_len_i     (word_len),
        .word_i         (word),
        .rf_rd_o        (rf_rd),
        .rf_wr_o        (rf_wr),
        .rf_page_o      (rf_page),
        .rf_ofs_o       (rf_ofs),
        .rf_wdata_o     (rf_wdata),
        .rf_rdata_i     (rf_rdata),
        .rf_hit_i       (rf_hit),
        .rd_valid_o     (rd_valid),
        .rd_data_o      (rd_data),
        .err_overrun_o  (e_ovr),
        .err_underrun_o (e_und),
        .err_page_o     (e_pg),
        .err_len_o      (e_len),
        .soft_rst_o     (srst)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_rd(input int p, input int o);
        if (p >= 3) return 16'hFFFF;
        if (p == 1 && o == 4) return 16'hFFFF;
        if (o >= 40) return 16'hFFFF;
        return {2'b10, 4'(p), 6'(o), 4'h3};
    endfunction

    task automatic xfer(input logic [15:0] w, input logic [4:0] len = 5'd16);
        @(negedge clk);
        word_valid = 1'b1;
        word = w;
        word_len = len;
        #1;
        c_rd = rf_rd; c_wr = rf_wr; c_page = rf_page; c_ofs = rf_ofs; c_wdata = rf_wdata;
        @(negedge clk);
        word_valid = 1'b0;
        word = '0;
        word_len = 5'd16;
        r_valid = rd_valid; r_data = rd_data; r_ovr = e_ovr; r_und = e_und;
        r_pg = e_pg; r_len = e_len; r_srst = srst;
    endtask

    function automatic logic [15:0] mk_cmd(input bit rd, input int p, input int o);
        return {rd, 4'(p), 6'(o), 5'b00001};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11 outputs", {rd_valid, e_ovr, e_und, e_pg, e_len, srst, rf_rd, rf_wr}, 0);
        chk("R11 addr", {rf_page, rf_ofs}, 0);

        // R6: zero word from reset is an underrun read at page 0 offset 0
        xfer(16'h0000);
        chk("R6 rd strobe", {c_rd, c_page, c_ofs}, {1'b1, 4'd0, 6'd0});
        chk("R6 underrun", {r_valid, r_und, r_ovr}, 3'b110);
        chk("R6 data", r_data, exp_rd(0, 0));

        // R2/R3/R7/R10: write sweep over every page and offset
        for (int p = 0; p < 4; p++) begin
            for (int o = 0; o < 64; o++) begin
                logic [15:0] d;
                bit exp_wr;
                d = (o == 0) ? 16'h0000 : {4'(p), 6'(o), 6'h15};
                exp_wr = (p < 3) && !(p == 1 && o == 4);
                xfer(mk_cmd(1'b0, p, o));
                chk("R2 latch quiet", {c_rd, c_wr, r_valid, r_pg}, 4'b0000);
                xfer(d);
                chk("R3 write strobe", {c_wr, c_rd}, {exp_wr, 1'b0});
                if (exp_wr) chk("R3 write addr", {c_page, c_ofs, c_wdata}, {4'(p), 6'(o), d});
                chk("R7 page flag", {r_pg, r_valid, r_srst}, {(p >= 3), 2'b00});
            end
        end

        // R4/R7/R8/R10: sequential reads covering every offset and the wrap
        for (int p = 0; p < 4; p++) begin
            xfer({1'b1, 4'(p), 6'd0, 5'b00000} | 16'h0001);
            for (int k = 0; k < 65; k++) begin
                int o;
                bit exp_rd_stb;
                o = k % 64;
                exp_rd_stb = (p < 3) && !(p == 1 && o == 4);
                xfer(16'h0000);
                chk("R4 read strobe", {c_rd, c_wr, c_ofs}, {exp_rd_stb, 1'b0, 6'(o)});
                chk("R8 R10 read data", r_data, exp_rd(p, o));
                chk("R4 R7 flags", {r_valid, r_und, r_ovr, r_pg}, {3'b100, (p >= 3)});
            end
        end

        // R5: overrun word performs the read and is discarded
        xfer(mk_cmd(1'b1, 2, 10));
        xfer(16'h0A5A);
        chk("R5 overrun read", {c_rd, c_wr, c_page, c_ofs}, {2'b10, 4'd2, 6'd10});
        chk("R5 overrun flag", {r_valid, r_ovr, r_und}, 3'b110);
        chk("R5 data", r_data, exp_rd(2, 10));
        xfer(16'h0000);
        chk("R5 not latched", {c_rd, c_page, c_ofs}, {1'b1, 4'd2, 6'd11});
        chk("R5 next clean", {r_ovr, r_und}, 2'b00);

        // R6: zero word after a write is an underrun at the unchanged offset
        xfer(mk_cmd(1'b0, 0, 7));
        xfer(16'h0005);
        xfer(16'h0000);
        chk("R6 after write", {c_rd, c_ofs, r_und}, {1'b1, 6'd7, 1'b1});

        // R9: reset key
        xfer(mk_cmd(1'b0, 1, 4));
        xfer(16'hBB00);
        chk("R9 no write", c_wr, 1'b0);
        chk("R9 pulse", r_srst, 1'b1);
        xfer(16'h0000);
        chk("R9 cleared", {c_rd, c_page, c_ofs, r_und}, {1'b1, 4'd0, 6'd0, 1'b1});

        // R10: other value at the key location is ignored
        xfer(mk_cmd(1'b0, 1, 4));
        xfer(16'hBB01);
        chk("R10 ignored", {c_wr, r_srst}, 2'b00);
        xfer(16'h0000);
        chk("R10 state kept", {c_rd, c_page, c_ofs}, {1'b0, 4'd1, 6'd4});
        chk("R10 read fill", {r_data, r_und}, {16'hFFFF, 1'b1});

        // R1: every bad length is ignored while a read is pending
        xfer(mk_cmd(1'b1, 0, 3));
        for (int l = 0; l < 32; l++) begin
            if (l != 16) begin
                xfer(16'h8000 | 16'(l), 5'(l));
                chk("R1 no strobe", {c_rd, c_wr}, 2'b00);
                chk("R1 flag", {r_len, r_valid, r_ovr}, 3'b100);
            end
        end
        xfer(16'h0000);
        chk("R1 state kept", {c_rd, c_ofs, r_und, r_len}, {1'b1, 6'd3, 1'b0, 1'b0});

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule